// File: doc/BRIEF.md
# Character LCD Power-Up Sequencer

This block drives the parallel bus of a character LCD module from the host side. After reset it runs the fixed power-on ritual such a display needs before it will accept anything else. It waits for the supply to settle and sends three blind "8-bit bus" function-set transfers with the required settling gaps between them. In 4-bit builds it then sends a single nibble that moves the display onto a 4-bit bus. It then sends four configuration commands: function set, display off, clear, and entry mode. Every gap is derived from a clock-frequency parameter and rounded up, so each minimum wait is met at any clock rate. The busy flag is never read.

When the last wait has elapsed, the block raises `cmd_ready`. From then on it accepts command bytes (`cmd_rs = 0`) and data bytes (`cmd_rs = 1`) through a valid/ready handshake. Each accepted byte goes out with the same transfer shape, the same nibble splitting and the same waiting rules as the start-up commands. The bus width (4 or 8 lines) is a build parameter. The line count, font, address direction and scroll flag are configuration inputs.

Top module: `lcd_init_seq`

## Requirements
- R1: While reset is high, and in the first cycle after it, `lcd_e`, `lcd_rs`, `lcd_rw` and `cmd_ready` are all 0.
- R2: The first rise of `lcd_e` after reset comes no earlier than ceil(15 ms × CLK_HZ) cycles after reset is released.
- R3: The first three transfers carry 0011 on DB7..DB4, as the byte 0x30 on an 8-bit bus or the nibble 0x3 on a 4-bit bus. The gap from the fall of E to the next rise of E is at least ceil(4.1 ms × CLK_HZ) after the first transfer and at least ceil(100 µs × CLK_HZ) after the second.
- R4: With BUS_W = 4, the fourth transfer is the single nibble 0x2. Every later byte goes out as two transfers, high nibble first. The second transfer of a pair rises within 3 cycles of the fall of the first.
- R5: The configuration bytes follow in this order. Function set is 0x20 | DL<<4 | N<<3 | F<<2, where DL = 1 only on an 8-bit bus, N = `cfg_two_lines` and F = `cfg_tall_font`. Display off is 0x08. Clear is 0x01. Entry mode is 0x04 | `cfg_addr_inc`<<1 | `cfg_scroll`.
- R6: Every start-up transfer has `lcd_rs` = 0 and `lcd_rw` = 0.
- R7: After the clear command the next transfer (or `cmd_ready`) waits at least ceil(1.52 ms × CLK_HZ) cycles. After every other byte it waits at least ceil(38 µs × CLK_HZ) cycles, measured from the fall of E.
- R8: In each transfer, RS and the data lines are stable for one cycle before E rises. E then stays high for exactly E_CYC cycles, and RS and the data lines stay unchanged while E is high and for one cycle after E falls.
- R9: `cmd_ready` first rises only after every start-up transfer has been sent and the final wait has elapsed.
- R10: A byte accepted on `cmd_valid && cmd_ready` is sent with `lcd_rs` = `cmd_rs` and uses the nibble rule of R4. `cmd_ready` drops in the next cycle. A command byte (`cmd_rs` = 0) of 0x01, 0x02 or 0x03 is followed by the long wait of R7; any other byte is followed by the short wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cfg_two_lines | input | 1 | Line-count bit placed in function set |
| cfg_tall_font | input | 1 | Font-height bit placed in function set |
| cfg_addr_inc | input | 1 | Address-direction bit placed in entry mode |
| cfg_scroll | input | 1 | Scroll-on-write bit placed in entry mode |
| cmd_valid | input | 1 | Host offers a byte |
| cmd_ready | output | 1 | Block can take a byte |
| cmd_rs | input | 1 | 0 = command byte, 1 = data byte |
| cmd_data | input | 8 | Byte to send |
| lcd_rs | output | 1 | Register-select line of the display |
| lcd_rw | output | 1 | Read/write line, always write (0) |
| lcd_e | output | 1 | Enable strobe |
| lcd_db | output | BUS_W | Data lines DB7 down to DB(8-BUS_W) |

## Verification
The sequencer runs in two builds at once: an 8-bit build with two lines, short font, incrementing address and no scroll, and a 4-bit build with the opposite settings. The bytes and nibbles differ in every configuration field and in the DL bit, so a dropped or swapped field shows up as a wrong value. User traffic combines a data byte with a command whose value matches the clear command, and a data byte whose nibbles differ, with a return-home command. These pairs separate RS handling from the long-wait decode and show whether the high nibble really goes first. Every gap is compared against the cycle count the bench computes itself from the time rules, so a wait that is too short is caught at the port.

// File: rtl/lcd_init_pkg.sv
package lcd_init_pkg;

  // which settling time follows a transfer
  typedef enum logic [1:0] {
    WT_CMD,   // ordinary command or data byte
    WT_CLR,   // clear / home
    WT_MID,   // after second blind function set
    WT_LONG   // after first blind function set
  } wait_e;

  typedef struct packed {
    logic [7:0] byte_v;
    logic       single;  // 4-bit bus: send the high nibble only
    wait_e      wsel;
  } step_t;

  // nanoseconds to clock cycles, rounded up, never zero
  function automatic int unsigned ns_to_cyc(longint unsigned ns, longint unsigned hz);
    longint unsigned c;
    c = (ns * hz + 64'd999_999_999) / 64'd1_000_000_000;
    if (c == 0) c = 1;
    return c[31:0];
  endfunction

endpackage

// File: rtl/lcd_wait_timer.sv
module lcd_wait_timer #(
  parameter int          CW      = 20,
  parameter logic [CW-1:0] RST_VAL = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          expired
);

  logic [CW-1:0] count;

  always_ff @(posedge clk) begin
    if (rst)               count <= RST_VAL;
    else if (load)         count <= load_val;
    else if (count != '0)  count <= count - 1'b1;
  end

  assign expired = (count == '0);

  AST_NO_RELOAD_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
    (!load && expired) |=> expired); // R7

endmodule

// File: rtl/lcd_bus_phy.sv
module lcd_bus_phy #(
  parameter int BUS_W = 8,
  parameter int E_CYC = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             rs,
  input  logic [7:0]       data,
  input  logic             single,
  output logic             busy,
  output logic             done,
  output logic             lcd_rs,
  output logic             lcd_e,
  output logic [BUS_W-1:0] lcd_db
);

  localparam bit FOUR = (BUS_W == 4);
  localparam int ECW  = (E_CYC > 1) ? $clog2(E_CYC) : 1;

  typedef enum logic [1:0] {P_IDLE, P_SETUP, P_PULSE, P_HOLD} pst_e;

  pst_e             st;
  logic [ECW-1:0]   ecnt;
  logic             lo_pend;
  logic [BUS_W-1:0] lo_q;
  logic [BUS_W-1:0] first_w;
  logic [BUS_W-1:0] second_w;

  // first transfer carries the top lines of the byte; on a 4-bit bus the
  // second carries the low nibble
  generate
    if (FOUR) begin : g_nib
      assign first_w  = data[7:4];
      assign second_w = data[3:0];
    end else begin : g_byte
      assign first_w  = data[BUS_W-1:0];
      assign second_w = data[BUS_W-1:0];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= P_IDLE;
      ecnt    <= '0;
      lo_pend <= 1'b0;
      lo_q    <= '0;
      done    <= 1'b0;
      lcd_rs  <= 1'b0;
      lcd_e   <= 1'b0;
      lcd_db  <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        P_IDLE: if (start) begin
          lcd_rs  <= rs;
          lcd_db  <= first_w;
          lo_q    <= second_w;
          lo_pend <= FOUR && !single;
          st      <= P_SETUP;
        end
        P_SETUP: begin
          lcd_e <= 1'b1;
          ecnt  <= ECW'(E_CYC - 1);
          st    <= P_PULSE;
        end
        P_PULSE: begin
          if (ecnt == '0) begin
            lcd_e <= 1'b0;
            st    <= P_HOLD;
          end else begin
            ecnt <= ecnt - 1'b1;
          end
        end
        P_HOLD: begin
          if (lo_pend) begin
            lcd_db  <= lo_q;
            lo_pend <= 1'b0;
            st      <= P_SETUP;
          end else begin
            done <= 1'b1;
            st   <= P_IDLE;
          end
        end
        default: st <= P_IDLE;
      endcase
    end
  end

  assign busy = (st != P_IDLE);

  AST_SETUP_BEFORE_E: assert property (@(posedge clk) disable iff (rst)
    $rose(lcd_e) |-> ($stable(lcd_db) && $stable(lcd_rs))); // R8

  AST_HOLD_WHILE_E: assert property (@(posedge clk) disable iff (rst)
    lcd_e |=> ($stable(lcd_db) && $stable(lcd_rs))); // R8

  AST_DONE_AFTER_LOW_E: assert property (@(posedge clk) disable iff (rst)
    done |-> !lcd_e); // R8

endmodule

// File: rtl/lcd_init_seq.sv
module lcd_init_seq
  import lcd_init_pkg::*;
#(
  parameter int unsigned CLK_HZ = 50_000_000,
  parameter int          BUS_W  = 8,
  parameter int          E_CYC  = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_two_lines,
  input  logic             cfg_tall_font,
  input  logic             cfg_addr_inc,
  input  logic             cfg_scroll,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic             cmd_rs,
  input  logic [7:0]       cmd_data,
  output logic             lcd_rs,
  output logic             lcd_rw,
  output logic             lcd_e,
  output logic [BUS_W-1:0] lcd_db
);

  localparam bit          FOUR     = (BUS_W == 4);
  localparam int unsigned PWR_CYC  = ns_to_cyc(64'd15_000_000, CLK_HZ);
  localparam int unsigned LONG_CYC = ns_to_cyc(64'd4_100_000,  CLK_HZ);
  localparam int unsigned MID_CYC  = ns_to_cyc(64'd100_000,    CLK_HZ);
  localparam int unsigned CLR_CYC  = ns_to_cyc(64'd1_520_000,  CLK_HZ);
  localparam int unsigned CMD_CYC  = ns_to_cyc(64'd38_000,     CLK_HZ);
  localparam int          CW       = $clog2(PWR_CYC + 1);
  localparam logic [2:0]  LAST_IDX = 3'd7;

  typedef enum logic [2:0] {S_PWR, S_LOAD, S_ISSUE, S_XFER, S_GAP, S_READY} sst_e;

  sst_e          st;
  logic [2:0]    idx;
  logic          is_user;
  logic [7:0]    cur_byte;
  logic          cur_rs;
  logic          cur_single;
  wait_e         cur_wsel;
  logic          phy_start;
  logic          phy_busy;
  logic          phy_done;
  logic          tmr_load;
  logic          tmr_expired;
  logic [CW-1:0] tmr_val;
  step_t         step_now;

  // start-up list; logical step 3 is the bus-width switch, skipped on 8 lines
  function automatic step_t init_step(input logic [2:0] i);
    step_t s;
    case (i)
      3'd0:    s = '{byte_v: 8'h30, single: 1'b1, wsel: WT_LONG};
      3'd1:    s = '{byte_v: 8'h30, single: 1'b1, wsel: WT_MID};
      3'd2:    s = '{byte_v: 8'h30, single: 1'b1, wsel: WT_CMD};
      3'd3:    s = '{byte_v: 8'h20, single: 1'b1, wsel: WT_CMD};
      3'd4:    s = '{byte_v: {3'b001, !FOUR, cfg_two_lines, cfg_tall_font, 2'b00},
                     single: 1'b0, wsel: WT_CMD};
      3'd5:    s = '{byte_v: 8'h08, single: 1'b0, wsel: WT_CMD};
      3'd6:    s = '{byte_v: 8'h01, single: 1'b0, wsel: WT_CLR};
      default: s = '{byte_v: {5'b00001, cfg_addr_inc, cfg_scroll}, single: 1'b0,
                     wsel: WT_CMD};
    endcase
    return s;
  endfunction

  assign step_now  = init_step(idx);
  assign phy_start = (st == S_ISSUE);
  assign tmr_load  = (st == S_XFER) && phy_done;

  always_comb begin
    case (cur_wsel)
      WT_LONG: tmr_val = CW'(LONG_CYC);
      WT_MID:  tmr_val = CW'(MID_CYC);
      WT_CLR:  tmr_val = CW'(CLR_CYC);
      default: tmr_val = CW'(CMD_CYC);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= S_PWR;
      idx        <= 3'd0;
      is_user    <= 1'b0;
      cur_byte   <= 8'h00;
      cur_rs     <= 1'b0;
      cur_single <= 1'b0;
      cur_wsel   <= WT_CMD;
      cmd_ready  <= 1'b0;
    end else begin
      case (st)
        S_PWR: if (tmr_expired) st <= S_LOAD;
        S_LOAD: begin
          cur_byte   <= step_now.byte_v;
          cur_single <= step_now.single;
          cur_wsel   <= step_now.wsel;
          cur_rs     <= 1'b0;
          st         <= S_ISSUE;
        end
        S_ISSUE: st <= S_XFER;
        S_XFER:  if (phy_done) st <= S_GAP;
        S_GAP: if (tmr_expired) begin
          if (is_user || idx == LAST_IDX) begin
            is_user   <= 1'b1;
            cmd_ready <= 1'b1;
            st        <= S_READY;
          end else begin
            idx <= (idx == 3'd2 && !FOUR) ? 3'd4 : idx + 3'd1;
            st  <= S_LOAD;
          end
        end
        S_READY: if (cmd_valid) begin
          cur_byte   <= cmd_data;
          cur_rs     <= cmd_rs;
          cur_single <= 1'b0;
          cur_wsel   <= (!cmd_rs && cmd_data[7:2] == 6'd0 && cmd_data[1:0] != 2'd0)
                        ? WT_CLR : WT_CMD;
          cmd_ready  <= 1'b0;
          st         <= S_ISSUE;
        end
        default: st <= S_PWR;
      endcase
    end
  end

  lcd_wait_timer #(
    .CW      (CW),
    .RST_VAL (CW'(PWR_CYC))
  ) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_expired)
  );

  lcd_bus_phy #(
    .BUS_W (BUS_W),
    .E_CYC (E_CYC)
  ) u_phy (
    .clk    (clk),
    .rst    (rst),
    .start  (phy_start),
    .rs     (cur_rs),
    .data   (cur_byte),
    .single (cur_single),
    .busy   (phy_busy),
    .done   (phy_done),
    .lcd_rs (lcd_rs),
    .lcd_e  (lcd_e),
    .lcd_db (lcd_db)
  );

  assign lcd_rw = 1'b0;

  AST_START_ON_IDLE_PHY: assert property (@(posedge clk) disable iff (rst)
    phy_start |-> !phy_busy); // R10

  AST_START_AFTER_WAIT: assert property (@(posedge clk) disable iff (rst)
    phy_start |-> tmr_expired); // R7

  AST_READY_WHEN_QUIET: assert property (@(posedge clk) disable iff (rst)
    cmd_ready |-> (!phy_busy && tmr_expired && !lcd_e)); // R9

  AST_READY_DROPS: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_ready) |=> !cmd_ready); // R10

endmodule

// File: tb/lcd_init_seq_bench.sv
module lcd_bus_mon #(
  parameter int DB_W  = 8,
  parameter int E_CYC = 3
) (
  input logic            clk,
  input logic            rst,
  input logic            e,
  input logic            rs,
  input logic            rw,
  input logic [DB_W-1:0] db
);
  logic [7:0] lg_db [0:31];
  logic       lg_rs [0:31];
  logic       lg_rw [0:31];
  int         rise_c [0:31];
  int         fall_c [0:31];
  int         n;
  int         cyc;
  int         viol;
  int         hi_cnt;
  logic            pe;
  logic            prs;
  logic [DB_W-1:0] pdb;

  always @(negedge clk) begin
    if (rst) begin
      cyc = 0; n = 0; viol = 0; hi_cnt = 0; pe = 1'b0; prs = 1'b0; pdb = '0;
    end else begin
      cyc = cyc + 1;
      if (e && !pe) begin
        if (db != pdb || rs != prs) viol = viol + 1;
        if (n < 32) begin
          lg_db[n] = 8'(db); lg_rs[n] = rs; lg_rw[n] = rw; rise_c[n] = cyc;
        end
        hi_cnt = 1;
      end else if (e) begin
        if (db != pdb || rs != prs) viol = viol + 1;
        hi_cnt = hi_cnt + 1;
      end else if (pe) begin
        if (db != pdb || rs != prs || hi_cnt != E_CYC) viol = viol + 1;
        if (n < 32) fall_c[n] = cyc;
        n = n + 1;
      end
      pe = e; prs = rs; pdb = db;
    end
  end
endmodule

module lcd_init_seq_bench;
  localparam int unsigned HZ = 1_000_000;
  localparam int          EC = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  int checks = 0;
  int fails  = 0;

  function automatic int cyc_of(longint ns);
    return int'((ns * HZ + 64'd999_999_999) / 64'd1_000_000_000);
  endfunction

  int W_PWR, W_LONG, W_MID, W_CLR, W_CMD;

  // 8-bit build
  logic       v8 = 1'b0, rs8 = 1'b0, rdy8;
  logic [7:0] d8 = 8'h00;
  logic       e8, lrs8, rw8;
  logic [7:0] db8;
  // 4-bit build
  logic       v4 = 1'b0, rs4 = 1'b0, rdy4;
  logic [7:0] d4 = 8'h00;
  logic       e4, lrs4, rw4;
  logic [3:0] db4;

  lcd_init_seq #(.CLK_HZ(HZ), .BUS_W(8), .E_CYC(EC)) u_lcd_init_seq (
    .clk(clk), .rst(rst), .cfg_two_lines(1'b1), .cfg_tall_font(1'b0),
    .cfg_addr_inc(1'b1), .cfg_scroll(1'b0), .cmd_valid(v8), .cmd_ready(rdy8),
    .cmd_rs(rs8), .cmd_data(d8), .lcd_rs(lrs8), .lcd_rw(rw8), .lcd_e(e8), .lcd_db(db8));

  lcd_init_seq #(.CLK_HZ(HZ), .BUS_W(4), .E_CYC(EC)) u_lcd_init_seq_n4 (
    .clk(clk), .rst(rst), .cfg_two_lines(1'b0), .cfg_tall_font(1'b1),
    .cfg_addr_inc(1'b0), .cfg_scroll(1'b1), .cmd_valid(v4), .cmd_ready(rdy4),
    .cmd_rs(rs4), .cmd_data(d4), .lcd_rs(lrs4), .lcd_rw(rw4), .lcd_e(e4), .lcd_db(db4));

  lcd_bus_mon #(.DB_W(8), .E_CYC(EC)) u_mon8 (
    .clk(clk), .rst(rst), .e(e8), .rs(lrs8), .rw(rw8), .db(db8));
  lcd_bus_mon #(.DB_W(4), .E_CYC(EC)) u_mon4 (
    .clk(clk), .rst(rst), .e(e4), .rs(lrs4), .rw(rw4), .db(db4));

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    summary();
  end

  task automatic t_reset();
    repeat (4) @(negedge clk);
    chk({e8, lrs8, rw8, rdy8, e4, lrs4, rw4, rdy4} == 8'd0, "R1", "outputs in reset",
        {e8, lrs8, rw8, rdy8, e4, lrs4, rw4, rdy4}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk({e8, lrs8, rw8, rdy8, e4, lrs4, rw4, rdy4} == 8'd0, "R1", "outputs after reset",
        {e8, lrs8, rw8, rdy8, e4, lrs4, rw4, rdy4}, 0);
  endtask

  task automatic t_init8();
    int exp_b [0:6];
    int gap_w [0:6];
    int r;
    exp_b = '{8'h30, 8'h30, 8'h30, 8'h38, 8'h08, 8'h01, 8'h06};
    gap_w = '{W_LONG, W_MID, W_CMD, W_CMD, W_CMD, W_CLR, W_CMD};
    while (!rdy8) @(negedge clk);
    r = u_mon8.cyc;
    chk(u_mon8.n == 7, "R9", "8-bit transfers before ready", u_mon8.n, 7);
    chk(u_mon8.rise_c[0] >= W_PWR, "R2", "8-bit power-up wait", u_mon8.rise_c[0], W_PWR);
    for (int i = 0; i < 7; i++) begin
      chk(int'(u_mon8.lg_db[i]) == exp_b[i], (i < 3) ? "R3" : "R5", "8-bit init byte",
          u_mon8.lg_db[i], exp_b[i]);
      chk(!u_mon8.lg_rs[i] && !u_mon8.lg_rw[i], "R6", "8-bit RS/RW", 
          {u_mon8.lg_rs[i], u_mon8.lg_rw[i]}, 0);
      if (i < 6)
        chk(u_mon8.rise_c[i+1] - u_mon8.fall_c[i] >= gap_w[i], (i < 2) ? "R3" : "R7",
            "8-bit gap", u_mon8.rise_c[i+1] - u_mon8.fall_c[i], gap_w[i]);
    end
    chk(r - u_mon8.fall_c[6] >= W_CMD, "R9", "8-bit ready after final wait",
        r - u_mon8.fall_c[6], W_CMD);
  endtask

  task automatic t_init4();
    int exp_n [0:11];
    int gap_w [0:11];
    int r;
    exp_n = '{3, 3, 3, 2, 2, 4, 0, 8, 0, 1, 0, 5};
    gap_w = '{W_LONG, W_MID, W_CMD, W_CMD, 0, W_CMD, 0, W_CMD, 0, W_CLR, 0, W_CMD};
    while (!rdy4) @(negedge clk);
    r = u_mon4.cyc;
    chk(u_mon4.n == 12, "R4", "4-bit transfers before ready", u_mon4.n, 12);
    chk(u_mon4.rise_c[0] >= W_PWR, "R2", "4-bit power-up wait", u_mon4.rise_c[0], W_PWR);
    for (int i = 0; i < 12; i++) begin
      chk(int'(u_mon4.lg_db[i]) == exp_n[i], (i < 3) ? "R3" : ((i == 3) ? "R4" : "R5"),
          "4-bit init nibble", u_mon4.lg_db[i], exp_n[i]);
      chk(!u_mon4.lg_rs[i] && !u_mon4.lg_rw[i], "R6", "4-bit RS/RW",
          {u_mon4.lg_rs[i], u_mon4.lg_rw[i]}, 0);
      if (i < 11) begin
        if (gap_w[i] == 0)
          chk(u_mon4.rise_c[i+1] - u_mon4.fall_c[i] <= 3, "R4", "nibble pair gap",
              u_mon4.rise_c[i+1] - u_mon4.fall_c[i], 3);
        else
          chk(u_mon4.rise_c[i+1] - u_mon4.fall_c[i] >= gap_w[i], (i < 2) ? "R3" : "R7",
              "4-bit gap", u_mon4.rise_c[i+1] - u_mon4.fall_c[i], gap_w[i]);
      end
    end
    chk(r - u_mon4.fall_c[11] >= W_CMD, "R9", "4-bit ready after final wait",
        r - u_mon4.fall_c[11], W_CMD);
  endtask

  task automatic send8(input logic rsv, input logic [7:0] b, output int r);
    @(negedge clk);
    v8 = 1'b1; rs8 = rsv; d8 = b;
    @(posedge clk);
    @(negedge clk);
    v8 = 1'b0;
    chk(!rdy8, "R10", "8-bit ready drops after accept", rdy8, 0);
    while (!rdy8) @(negedge clk);
    r = u_mon8.cyc;
  endtask

  task automatic send4(input logic rsv, input logic [7:0] b, output int r);
    @(negedge clk);
    v4 = 1'b1; rs4 = rsv; d4 = b;
    @(posedge clk);
    @(negedge clk);
    v4 = 1'b0;
    chk(!rdy4, "R10", "4-bit ready drops after accept", rdy4, 0);
    while (!rdy4) @(negedge clk);
    r = u_mon4.cyc;
  endtask

  task automatic t_user8();
    int n0, r;
    n0 = u_mon8.n;
    send8(1'b1, 8'h41, r);
    chk(u_mon8.n == n0 + 1, "R10", "8-bit data transfer count", u_mon8.n, n0 + 1);
    chk(u_mon8.lg_db[n0] == 8'h41 && u_mon8.lg_rs[n0], "R10", "8-bit data byte with RS=1",
        {u_mon8.lg_rs[n0], u_mon8.lg_db[n0]}, 9'h141);
    chk(r - u_mon8.fall_c[n0] >= W_CMD, "R10", "8-bit data wait", r - u_mon8.fall_c[n0], W_CMD);
    n0 = u_mon8.n;
    send8(1'b0, 8'h01, r);
    chk(u_mon8.lg_db[n0] == 8'h01 && !u_mon8.lg_rs[n0], "R10", "8-bit clear command",
        {u_mon8.lg_rs[n0], u_mon8.lg_db[n0]}, 9'h001);
    chk(r - u_mon8.fall_c[n0] >= W_CLR, "R10", "8-bit clear wait", r - u_mon8.fall_c[n0], W_CLR);
  endtask

  task automatic t_user4();
    int n0, r;
    n0 = u_mon4.n;
    send4(1'b1, 8'hA5, r);
    chk(u_mon4.n == n0 + 2, "R10", "4-bit data transfer count", u_mon4.n, n0 + 2);
    chk(u_mon4.lg_db[n0] == 8'h0A && u_mon4.lg_rs[n0], "R10", "4-bit data high nibble",
        {u_mon4.lg_rs[n0], u_mon4.lg_db[n0]}, 9'h10A);
    chk(u_mon4.lg_db[n0+1] == 8'h05 && u_mon4.lg_rs[n0+1], "R10", "4-bit data low nibble",
        {u_mon4.lg_rs[n0+1], u_mon4.lg_db[n0+1]}, 9'h105);
    n0 = u_mon4.n;
    send4(1'b0, 8'h02, r);
    chk(u_mon4.lg_db[n0] == 8'h00 && u_mon4.lg_db[n0+1] == 8'h02, "R10", "4-bit home nibbles",
        {u_mon4.lg_db[n0], u_mon4.lg_db[n0+1]}, 16'h0002);
    chk(r - u_mon4.fall_c[n0+1] >= W_CLR, "R10", "4-bit home wait",
        r - u_mon4.fall_c[n0+1], W_CLR);
  endtask

  initial begin
    W_PWR  = cyc_of(64'd15_000_000);
    W_LONG = cyc_of(64'd4_100_000);
    W_MID  = cyc_of(64'd100_000);
    W_CLR  = cyc_of(64'd1_520_000);
    W_CMD  = cyc_of(64'd38_000);
    t_reset();
    t_init8();
    t_init4();
    t_user8();
    t_user4();
    chk(u_mon8.viol == 0, "R8", "8-bit strobe shape violations", u_mon8.viol, 0);
    chk(u_mon4.viol == 0, "R8", "4-bit strobe shape violations", u_mon4.viol, 0);
    summary();
  end

endmodule